// File: doc/BRIEF.md
# Pulse-Width Write Frame Encoder

This block programs a low-frequency transponder by switching the reader field on and off through one modulation output. A high level on `mod_out` means the field is on and a low level means it is off. A one-cycle `start` strobe captures a 64-bit data word and a 16-bit check value. The block then keeps the field on for a charge period and sends a fixed 14-byte write frame. It keeps the field on for a programming hold and finally pulses `done`.

Each bit occupies a fixed 2 ms slot. The slot opens with a field-off gap, and the length of that gap carries the value: 1 ms for a one and 0.3 ms for a zero. The field is on for the rest of the slot. Every duration is a cycle count derived from the `CLK_HZ` parameter.

When the supplied check value is zero, the block first computes a CRC-16 over the data bytes and sends that instead. This costs eight extra clock cycles before the charge period begins.

The controller is a state machine with seven states:

- IDLE: waits for `start`. The field is on.
- CRC: eight cycles, one data byte per cycle.
- CHARGE: the charge period.
- GAP: the field-off part of a bit slot.
- MARK: the field-on remainder of a bit slot.
- HOLD: the programming hold.
- DONE: a single cycle that reports completion.

The transitions are:

- IDLE to CRC on `start` with a zero check value.
- IDLE to CHARGE on `start` with a nonzero check value.
- CRC to CHARGE after the eighth byte.
- CHARGE to GAP when the charge count expires.
- GAP to MARK when the gap count expires.
- MARK to GAP when the slot ends, if bits remain.
- MARK to HOLD when the slot of the final bit ends.
- HOLD to DONE when the hold count expires.
- DONE to IDLE unconditionally.

Top module: `pw_write_encoder`

## Requirements
- R1: Out of reset and whenever idle, `mod_out` is 1, `busy` is 0 and `done` is 0, and the block stays idle until `start` is seen.
- R2: A `start` seen while idle makes `busy` 1 from the next cycle and captures `data_in` and `chk_in`. A `start` seen while busy is ignored, and the frame in progress goes out unchanged.
- R3: Before the first bit the field is on for CLK_HZ*50/1000 cycles (50 ms). When `chk_in` was zero, 8 further field-on cycles of CRC computation precede it.
- R4: A one bit is the field off for CLK_HZ/1000 cycles (1 ms) and then on for the rest of a 2 ms slot. A zero bit is off for CLK_HZ*3/10000 cycles (0.3 ms) and then on for the rest of the slot. Every slot lasts CLK_HZ*2/1000 cycles.
- R5: The frame is 14 bytes, each sent least significant bit first. The byte order is:
  - 0xBB, then 0xEB;
  - data bytes, starting with `data_in[7:0]` and ending with `data_in[63:56]`;
  - the check low byte, then the check high byte;
  - 0x00, then 0x03.
- R6: A nonzero `chk_in` is sent exactly as given, whether or not it is a correct CRC.
- R7: A zero `chk_in` is replaced by a CRC-16 with the following definition:
  - generator 0x1021, processed in the least-significant-bit-first form with constant 0x8408;
  - initial value 0;
  - fed with the eight data bytes, lowest byte first.
- R8: After the last bit slot the field stays on for CLK_HZ*50/1000 cycles. In the next cycle `done` is 1 for exactly one cycle, and the block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a write frame (acted on only when idle) |
| data_in | input | 64 | Data word to program |
| chk_in | input | 16 | Check value; zero requests an internally computed CRC |
| mod_out | output | 1 | Field control: 1 = field on, 0 = field off |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The frame is decoded purely from the widths of the field-off pulses on `mod_out`, and each slot length is checked.

The stimulus table covers four cases, and each separates a different fault:

- A mixed-pattern word with a zero check value separates byte-order and bit-order faults, and exercises the CRC path.
- An all-ones word with a supplied check value separates the pass-through path from the CRC path.
- An all-zero word with a zero check value yields a CRC of zero, which must still be sent.
- A word with only its end bits set, paired with 0xFFFF, exposes shifted or truncated data fields.

A separate frame drives `start` again in the middle of transmission, with changed inputs, to confirm that the frame in progress is unaffected. The charge-to-first-gap and last-slot-to-`done` intervals are measured to the cycle.

// File: rtl/pwenc_pkg.sv
package pwenc_pkg;

    localparam int DATA_BYTES  = 8;
    localparam int FRAME_BYTES = DATA_BYTES + 6;
    localparam int IDX_W       = $clog2(FRAME_BYTES);

    localparam logic [7:0]  HDR_KEY   = 8'hBB;
    localparam logic [7:0]  HDR_PASS  = 8'hEB;
    localparam logic [7:0]  TRL_LO    = 8'h00;
    localparam logic [7:0]  TRL_HI    = 8'h03;
    localparam logic [15:0] CRC_RPOLY = 16'h8408;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CRC,
        S_CHARGE,
        S_GAP,
        S_MARK,
        S_HOLD,
        S_DONE
    } pw_state_e;

    // One byte through the right-shifting CRC-16 form.
    function automatic logic [15:0] crc16_byte(input logic [15:0] crc_i, input logic [7:0] b);
        logic [15:0] c;
        c = crc_i ^ {8'h00, b};
        for (int k = 0; k < 8; k++) begin
            c = c[0] ? ((c >> 1) ^ CRC_RPOLY) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/pwenc_timer.sv
module pwenc_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwenc_crc16.sv
module pwenc_crc16 import pwenc_pkg::*; (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc <= '0;
        else if (clr) crc <= '0;
        else if (en)  crc <= crc16_byte(crc, din);
    end
endmodule

// File: rtl/pwenc_frame_byte.sv
module pwenc_frame_byte import pwenc_pkg::*; (
    input  logic [8*DATA_BYTES-1:0] data,
    input  logic [15:0]             chk,
    input  logic [IDX_W-1:0]        idx,
    output logic [7:0]              byte_o
);
    logic [7:0] tbl [FRAME_BYTES];

    assign tbl[0] = HDR_KEY;
    assign tbl[1] = HDR_PASS;
    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_data
        assign tbl[2+i] = data[8*i +: 8];
    end
    assign tbl[DATA_BYTES+2] = chk[7:0];
    assign tbl[DATA_BYTES+3] = chk[15:8];
    assign tbl[DATA_BYTES+4] = TRL_LO;
    assign tbl[DATA_BYTES+5] = TRL_HI;

    always_comb begin
        byte_o = '0;
        for (int i = 0; i < FRAME_BYTES; i++) begin
            if (idx == IDX_W'(i)) byte_o = tbl[i];
        end
    end
endmodule

// File: rtl/pw_write_encoder.sv
module pw_write_encoder import pwenc_pkg::*; #(
    parameter int CLK_HZ = 24_000_000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [8*DATA_BYTES-1:0] data_in,
    input  logic [15:0]             chk_in,
    output logic                    mod_out,
    output logic                    busy,
    output logic                    done
);
    localparam longint HZ           = CLK_HZ;
    localparam int     CYC_CHARGE   = int'(HZ * 50 / 1000);
    localparam int     CYC_HOLD     = int'(HZ * 50 / 1000);
    localparam int     CYC_ONE_GAP  = int'(HZ / 1000);
    localparam int     CYC_ZERO_GAP = int'(HZ * 3 / 10000);
    localparam int     CYC_SLOT     = int'(HZ * 2 / 1000);
    localparam int     TW           = $clog2(CYC_CHARGE + 1);
    localparam int     BW           = $clog2(8);

    pw_state_e st, st_nx;

    logic [TW-1:0]           tmr_cnt;
    logic                    tmr_clr;
    logic [TW-1:0]           dur_m1;
    logic                    tmr_last;
    logic [8*DATA_BYTES-1:0] data_q;
    logic [15:0]             chk_q;
    logic                    use_crc_q;
    logic [15:0]             crc_val;
    logic [15:0]             chk_sel;
    logic [IDX_W-1:0]        byte_idx;
    logic [BW-1:0]           bit_idx;
    logic [7:0]              cur_byte;
    logic                    cur_bit;
    logic                    last_bit;
    logic                    accept;

    assign accept   = (st == S_IDLE) && start;
    assign chk_sel  = use_crc_q ? crc_val : chk_q;
    assign cur_bit  = cur_byte[bit_idx];
    assign last_bit = (byte_idx == IDX_W'(FRAME_BYTES - 1)) && (bit_idx == BW'(7));
    assign tmr_last = (tmr_cnt == dur_m1);
    assign tmr_clr  = (st_nx != st) || (st == S_IDLE);

    pwenc_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .cnt   (tmr_cnt)
    );

    pwenc_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (st == S_CRC),
        .din   (data_q[{tmr_cnt[2:0], 3'b000} +: 8]),
        .crc   (crc_val)
    );

    pwenc_frame_byte u_fbyte (
        .data   (data_q),
        .chk    (chk_sel),
        .idx    (byte_idx),
        .byte_o (cur_byte)
    );

    // Duration of the current state, minus one.
    always_comb begin
        unique case (st)
            S_CRC:    dur_m1 = TW'(DATA_BYTES - 1);
            S_CHARGE: dur_m1 = TW'(CYC_CHARGE - 1);
            S_GAP:    dur_m1 = cur_bit ? TW'(CYC_ONE_GAP - 1) : TW'(CYC_ZERO_GAP - 1);
            S_MARK:   dur_m1 = cur_bit ? TW'(CYC_SLOT - CYC_ONE_GAP - 1)
                                       : TW'(CYC_SLOT - CYC_ZERO_GAP - 1);
            S_HOLD:   dur_m1 = TW'(CYC_HOLD - 1);
            default:  dur_m1 = '0;
        endcase
    end

    // Next-state logic.
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:   if (start)    st_nx = (chk_in == '0) ? S_CRC : S_CHARGE;
            S_CRC:    if (tmr_last) st_nx = S_CHARGE;
            S_CHARGE: if (tmr_last) st_nx = S_GAP;
            S_GAP:    if (tmr_last) st_nx = S_MARK;
            S_MARK:   if (tmr_last) st_nx = last_bit ? S_HOLD : S_GAP;
            S_HOLD:   if (tmr_last) st_nx = S_DONE;
            S_DONE:                 st_nx = S_IDLE;
            default:                st_nx = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // Captured inputs and frame position.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q    <= '0;
            chk_q     <= '0;
            use_crc_q <= 1'b0;
            byte_idx  <= '0;
            bit_idx   <= '0;
        end else if (accept) begin
            data_q    <= data_in;
            chk_q     <= chk_in;
            use_crc_q <= (chk_in == '0);
            byte_idx  <= '0;
            bit_idx   <= '0;
        end else if (st == S_MARK && tmr_last && !last_bit) begin
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == BW'(7)) byte_idx <= byte_idx + 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        mod_out = (st != S_GAP);
        busy    = (st != S_IDLE);
        done    = (st == S_DONE);
    end

endmodule

// File: rtl/pwenc_checker.sv
module pwenc_checker #(
    parameter int CLK_HZ = 24_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic mod_out,
    input logic busy,
    input logic done
);
    localparam longint HZ       = CLK_HZ;
    localparam int     ONE_GAP  = int'(HZ / 1000);
    localparam int     ZERO_GAP = int'(HZ * 3 / 10000);
    localparam int     LW       = $clog2(ONE_GAP + 2) + 1;

    logic [LW-1:0] lo_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        lo_run <= '0;
        else if (!mod_out) lo_run <= lo_run + 1'b1;
        else               lo_run <= '0;
    end

    AST_IDLE_FIELD_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mod_out && !done)); // R1
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R2
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R2
    AST_GAP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        lo_run <= LW'(ONE_GAP)); // R4
    AST_GAP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_out && lo_run != '0) |-> (lo_run == LW'(ONE_GAP) || lo_run == LW'(ZERO_GAP))); // R4
    AST_DONE_FIELD_ON: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && mod_out)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R8

endmodule

bind pw_write_encoder pwenc_checker #(.CLK_HZ(CLK_HZ)) u_pwenc_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mod_out (mod_out),
    .busy    (busy),
    .done    (done)
);

// File: tb/pw_write_encoder_bench.sv
module pw_write_encoder_bench;
    localparam int CLK_HZ = 20_000;
    localparam int ZW     = CLK_HZ * 3 / 10000;  // 6
    localparam int OW     = CLK_HZ / 1000;       // 20
    localparam int SLOT   = CLK_HZ * 2 / 1000;   // 40
    localparam int CHG    = CLK_HZ * 50 / 1000;  // 1000
    localparam int HOLD   = CLK_HZ * 50 / 1000;  // 1000
    localparam int NBITS  = 112;

    typedef struct packed {
        logic [63:0] d;
        logic [15:0] c;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{d: 64'h0123_4567_89AB_CDEF, c: 16'h0000},
        '{d: 64'hFFFF_FFFF_FFFF_FFFF, c: 16'h1234},
        '{d: 64'h0000_0000_0000_0000, c: 16'h0000},
        '{d: 64'h8000_0000_0000_0001, c: 16'hFFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] data_in = '0;
    logic [15:0] chk_in = '0;
    logic        mod_out, busy, done;

    int n_checks = 0;
    int n_errs   = 0;

    always #5 clk = ~clk;

    pw_write_encoder #(.CLK_HZ(CLK_HZ)) u_pw_write_encoder (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .data_in (data_in),
        .chk_in  (chk_in),
        .mod_out (mod_out),
        .busy    (busy),
        .done    (done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference CRC per R7: right-shifting form, constant 0x8408, init 0.
    function automatic logic [15:0] ref_crc(input logic [63:0] d);
        logic [15:0] c = '0;
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < 8; k++) begin
                if (c[0] ^ d[8*i+k]) c = (c >> 1) ^ 16'h8408;
                else                 c = c >> 1;
            end
        end
        return c;
    endfunction

    task automatic run_frame(input logic [63:0] d, input logic [15:0] c, input bit inject);
        logic [15:0]      ce;
        logic [NBITS-1:0] rx;
        int n, w, h, bad_w, bad_slot;
        bit early;
        ce = (c == 16'h0) ? ref_crc(d) : c;
        rx = '0; bad_w = 0; bad_slot = 0; early = 0;
        @(negedge clk);
        data_in = d; chk_in = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2 busy after start", 64'(busy), 64'd1);
        n = 0;
        while (mod_out === 1'b1) begin
            n++;
            @(negedge clk);
        end
        check(n == CHG + ((c == 16'h0) ? 8 : 0), "R3 charge length", 64'(n),
              64'(CHG + ((c == 16'h0) ? 8 : 0)));
        for (int k = 0; k < NBITS; k++) begin
            w = 0;
            while (mod_out === 1'b0) begin
                if (inject && k == 20 && w == 0) begin
                    start = 1'b1; data_in = ~d; chk_in = 16'h5555;
                end
                w++;
                @(negedge clk);
                start = 1'b0;
            end
            h = 0;
            while (mod_out === 1'b1 && done !== 1'b1) begin
                h++;
                @(negedge clk);
            end
            rx[k] = (w == OW);
            if (w != OW && w != ZW) bad_w++;
            if (k < NBITS - 1) begin
                if (w + h != SLOT) bad_slot++;
                if (done === 1'b1) begin
                    early = 1;
                    break;
                end
            end else begin
                check(h == SLOT - w + HOLD, "R8 hold length", 64'(h), 64'(SLOT - w + HOLD));
                check(done === 1'b1, "R8 done after hold", 64'(done), 64'd1);
            end
        end
        check(!early, "R5 frame bit count", 64'(early), 64'd0);
        check(bad_w == 0, "R4 gap widths", 64'(bad_w), 64'd0);
        check(bad_slot == 0, "R4 slot length", 64'(bad_slot), 64'd0);
        check(rx[15:0] == 16'hEBBB, "R5 header bytes", 64'(rx[15:0]), 64'hEBBB);
        check(rx[79:16] == d, "R5 data bytes", rx[79:16], d);
        if (c == 16'h0) check(rx[95:80] == ce, "R7 computed crc", 64'(rx[95:80]), 64'(ce));
        else            check(rx[95:80] == ce, "R6 supplied check", 64'(rx[95:80]), 64'(ce));
        check(rx[111:96] == 16'h0300, "R5 trailer bytes", 64'(rx[111:96]), 64'h0300);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R8 single done then idle",
              64'({done, busy}), 64'd0);
        check(mod_out === 1'b1, "R1 field on after frame", 64'(mod_out), 64'd1);
    endtask

    initial begin : watchdog
        repeat (150_000) @(posedge clk);
        n_errs++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(mod_out === 1'b1 && busy === 1'b0 && done === 1'b0, "R1 in reset",
              64'({mod_out, busy, done}), 64'b100);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        check(mod_out === 1'b1 && busy === 1'b0 && done === 1'b0, "R1 idle without start",
              64'({mod_out, busy, done}), 64'b100);

        for (int v = 0; v < 4; v++) begin
            run_frame(VECS[v].d, VECS[v].c, 1'b0);
        end

        // Restart attempt mid-frame must not disturb the frame (R2).
        run_frame(64'hA5C3_0F96_1E2D_3C4B, 16'hBEEF, 1'b1);

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule